// File: doc/BRIEF.md
# Pointer-Indexed Timekeeping Register Window

This block gives software a narrow 16-bit view onto a set of calendar and time bytes. The bytes are grouped into pairs. Four pairs hold the running time and four hold the alarm setting. Software does not address each pair directly. It reaches the time pairs through one data window and the alarm pairs through a second data window. A 2-bit pointer for each window selects which pair is visible.

The pointer moves down by itself as the window is used. Any read of a window steps it, and any write that touches the high byte steps it. It stops at zero rather than wrapping around. Software can therefore load the pointer once and then stream a whole record through the window, from the year down to the minutes and seconds.

A control word holds the time pointer and a write-enable bit, and an alarm configuration word holds the alarm pointer. Writes to the time bytes only take effect while the write-enable bit is set. That bit can only be raised while an external unlock input is high. Every stored byte is presented on flat output buses to a separate time-counting engine.

Top module: `tkw_window`

## Requirements
- R1: Address 0 is the control word and address 2 is the alarm configuration word. In both, bits 9:8 hold the window pointer, and a bus write with byte enable bit 1 set loads those bits directly. The control word also carries the timer write-enable flag in bit 13. All other bits read as zero, and reading either word has no side effect.
- R2: Address 1 is the time window. Each time pointer value maps a pair as low byte / high byte: pointer 0 gives seconds / minutes, 1 gives hours / weekday, 2 gives day / month, and 3 gives year / unused. The unused byte reads as zero and ignores writes.
- R3: Address 3 is the alarm window. Each alarm pointer value maps a pair as low byte / high byte: pointer 0 gives seconds / minutes, 1 gives hours / weekday, and 2 gives day / month. Pointer 3 reads as zero in both bytes and ignores writes.
- R4: A window write with byte enable bit 1 set lowers that window's pointer by one at the next clock edge. A write with only byte enable bit 0 set leaves the pointer unchanged.
- R5: A pointer at zero stays at zero on any further window access, until software loads a new value.
- R6: A read of a window (bus_rd with address 1 or 3) presents the pair at the current pointer on bus_rdata in the same cycle. That window's pointer then steps down at the next edge, whatever byte enables are given.
- R7: Writes to the time bytes are stored only while the write-enable flag is 1. Otherwise the data is discarded, but a high-byte write still steps the time pointer.
- R8: A control write can change the write-enable flag from 0 to 1 only while wr_unlock is high. Clearing the flag, or keeping it at 1, needs no unlock.
- R9: Alarm byte writes do not depend on the write-enable flag.
- R10: A write with both byte enables set stores both bytes into the pair selected by the pointer before its decrement.
- R11: After reset both pointers and the write-enable flag are 0, and every stored byte is 0.
- R12: Only the byte lanes whose enable is set are written. Byte enable bit 0 covers bits 7:0 and byte enable bit 1 covers bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | 0 control, 1 time window, 2 alarm configuration, 3 alarm window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_be | input | 2 | Byte enables, bit 1 for the high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| wr_unlock | input | 1 | Permits the write-enable flag to be raised |
| tm_lo_q | output | 32 | Time low bytes, byte k is pair k (seconds, hours, day, year) |
| tm_hi_q | output | 32 | Time high bytes, byte k is pair k (minutes, weekday, month, zero) |
| al_lo_q | output | 32 | Alarm low bytes, byte k is pair k (seconds, hours, day, zero) |
| al_hi_q | output | 32 | Alarm high bytes, byte k is pair k (minutes, weekday, month, zero) |

## Verification
Read data is combinational, so the bench checks bus_rdata 1 ns after driving the inputs on the falling edge, in the same cycle as the read strobe. Pointer steps, pointer loads, changes to the write-enable flag and stored bytes all take effect at the next rising edge. The bench observes each of them one access later, through a following read or the field output buses, and never before that edge has passed. The reset values are checked 1 ns after reset is asserted, with reset held low.

// File: rtl/tkw_pkg.sv
package tkw_pkg;

  localparam int unsigned PTR_W   = 2;
  localparam int unsigned N_PAIRS = 2 ** PTR_W;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TVAL = 2'd1,
    SEL_ACFG = 2'd2,
    SEL_AVAL = 2'd3
  } win_sel_e;

  // Next pointer: a load wins, otherwise a step lowers it and stops at zero.
  function automatic ptr_t ptr_next(ptr_t cur, logic load, ptr_t load_val, logic step);
    if (load) return load_val;
    if (step && (cur != '0)) return cur - ptr_t'(1);
    return cur;
  endfunction

  // Write-enable flag: raising it needs unlock, clearing or holding does not.
  function automatic logic wren_next(logic cur, logic wr, logic req, logic unlock);
    if (!wr) return cur;
    return req & (cur | unlock);
  endfunction

endpackage

// File: rtl/tkw_decode.sv
module tkw_decode
  import tkw_pkg::*;
(
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_be,
  output logic       ctrl_ld,
  output logic       acfg_ld,
  output logic       tm_lo_wr,
  output logic       tm_hi_wr,
  output logic       al_lo_wr,
  output logic       al_hi_wr,
  output logic       tm_step,
  output logic       al_step
);

  win_sel_e sel;
  logic     hit_ctrl, hit_tval, hit_acfg, hit_aval;

  assign sel      = win_sel_e'(bus_addr);
  assign hit_ctrl = (sel == SEL_CTRL);
  assign hit_tval = (sel == SEL_TVAL);
  assign hit_acfg = (sel == SEL_ACFG);
  assign hit_aval = (sel == SEL_AVAL);

  // Only the high lane holds the pointer bits of a configuration word.
  assign ctrl_ld  = bus_wr & hit_ctrl & bus_be[1];
  assign acfg_ld  = bus_wr & hit_acfg & bus_be[1];

  assign tm_lo_wr = bus_wr & hit_tval & bus_be[0];
  assign tm_hi_wr = bus_wr & hit_tval & bus_be[1];
  assign al_lo_wr = bus_wr & hit_aval & bus_be[0];
  assign al_hi_wr = bus_wr & hit_aval & bus_be[1];

  // Reads of either lane, or high-lane writes, step the pointer once.
  assign tm_step  = hit_tval & (bus_rd | (bus_wr & bus_be[1]));
  assign al_step  = hit_aval & (bus_rd | (bus_wr & bus_be[1]));

endmodule

// File: rtl/tkw_ptr.sv
module tkw_ptr
  import tkw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  ptr_t load_val,
  input  logic step,
  output ptr_t ptr
);

  ptr_t ptr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_r <= '0;
    else        ptr_r <= ptr_next(ptr_r, load, load_val, step);
  end

  assign ptr = ptr_r;

endmodule

// File: rtl/tkw_bank.sv
module tkw_bank #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_PAIRS = 4,
  parameter logic [N_PAIRS-1:0] LO_MASK = '1,
  parameter logic [N_PAIRS-1:0] HI_MASK = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(N_PAIRS)-1:0]  sel,
  input  logic                        wr_lo,
  input  logic                        wr_hi,
  input  logic [2*BYTE_W-1:0]         wdata,
  output logic [2*BYTE_W-1:0]         rd_pair,
  output logic [N_PAIRS*BYTE_W-1:0]   lo_q,
  output logic [N_PAIRS*BYTE_W-1:0]   hi_q
);

  localparam int unsigned SEL_W = $clog2(N_PAIRS);

  logic [BYTE_W-1:0] lo_b [N_PAIRS];
  logic [BYTE_W-1:0] hi_b [N_PAIRS];

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    if (LO_MASK[k]) begin : g_lo
      logic [BYTE_W-1:0] lo_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lo_r <= '0;
        else if (wr_lo && (sel == SEL_W'(k))) lo_r <= wdata[BYTE_W-1:0];
      end
      assign lo_b[k] = lo_r;
    end else begin : g_lo_none
      assign lo_b[k] = '0;
    end

    if (HI_MASK[k]) begin : g_hi
      logic [BYTE_W-1:0] hi_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_r <= '0;
        else if (wr_hi && (sel == SEL_W'(k))) hi_r <= wdata[2*BYTE_W-1:BYTE_W];
      end
      assign hi_b[k] = hi_r;
    end else begin : g_hi_none
      assign hi_b[k] = '0;
    end

    assign lo_q[k*BYTE_W +: BYTE_W] = lo_b[k];
    assign hi_q[k*BYTE_W +: BYTE_W] = hi_b[k];
  end

  always_comb begin
    rd_pair = '0;
    for (int k = 0; k < N_PAIRS; k++) begin
      if (sel == SEL_W'(k)) rd_pair = {hi_b[k], lo_b[k]};
    end
  end

endmodule

// File: rtl/tkw_window.sv
module tkw_window
  import tkw_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PTR_LSB  = 8,
  parameter int unsigned WREN_BIT = 13,
  parameter logic [N_PAIRS-1:0] TM_LO_MASK = 4'b1111,
  parameter logic [N_PAIRS-1:0] TM_HI_MASK = 4'b0111,
  parameter logic [N_PAIRS-1:0] AL_LO_MASK = 4'b0111,
  parameter logic [N_PAIRS-1:0] AL_HI_MASK = 4'b0111
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     bus_addr,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [1:0]                     bus_be,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic                           wr_unlock,
  output logic [N_PAIRS*(DATA_W/2)-1:0]  tm_lo_q,
  output logic [N_PAIRS*(DATA_W/2)-1:0]  tm_hi_q,
  output logic [N_PAIRS*(DATA_W/2)-1:0]  al_lo_q,
  output logic [N_PAIRS*(DATA_W/2)-1:0]  al_hi_q
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  // Decoded events, named for the checker.
  logic ctrl_ld, acfg_ld;
  logic tm_lo_wr, tm_hi_wr, al_lo_wr, al_hi_wr;
  logic tm_lo_wr_g, tm_hi_wr_g;
  logic tm_step, al_step;
  logic wren;
  ptr_t tm_ptr, al_ptr;
  ptr_t ptr_wval;
  logic [DATA_W-1:0] tm_pair, al_pair;

  tkw_decode u_decode (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_be   (bus_be),
    .ctrl_ld  (ctrl_ld),
    .acfg_ld  (acfg_ld),
    .tm_lo_wr (tm_lo_wr),
    .tm_hi_wr (tm_hi_wr),
    .al_lo_wr (al_lo_wr),
    .al_hi_wr (al_hi_wr),
    .tm_step  (tm_step),
    .al_step  (al_step)
  );

  assign ptr_wval = bus_wdata[PTR_LSB +: PTR_W];

  tkw_ptr u_tm_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctrl_ld),
    .load_val (ptr_wval),
    .step     (tm_step),
    .ptr      (tm_ptr)
  );

  tkw_ptr u_al_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acfg_ld),
    .load_val (ptr_wval),
    .step     (al_step),
    .ptr      (al_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wren <= 1'b0;
    else        wren <= wren_next(wren, ctrl_ld, bus_wdata[WREN_BIT], wr_unlock);
  end

  // Time byte writes are gated, alarm byte writes are not.
  assign tm_lo_wr_g = tm_lo_wr & wren;
  assign tm_hi_wr_g = tm_hi_wr & wren;

  tkw_bank #(
    .BYTE_W  (BYTE_W),
    .N_PAIRS (N_PAIRS),
    .LO_MASK (TM_LO_MASK),
    .HI_MASK (TM_HI_MASK)
  ) u_tm_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (tm_ptr),
    .wr_lo   (tm_lo_wr_g),
    .wr_hi   (tm_hi_wr_g),
    .wdata   (bus_wdata),
    .rd_pair (tm_pair),
    .lo_q    (tm_lo_q),
    .hi_q    (tm_hi_q)
  );

  tkw_bank #(
    .BYTE_W  (BYTE_W),
    .N_PAIRS (N_PAIRS),
    .LO_MASK (AL_LO_MASK),
    .HI_MASK (AL_HI_MASK)
  ) u_al_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (al_ptr),
    .wr_lo   (al_lo_wr),
    .wr_hi   (al_hi_wr),
    .wdata   (bus_wdata),
    .rd_pair (al_pair),
    .lo_q    (al_lo_q),
    .hi_q    (al_hi_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (win_sel_e'(bus_addr))
      SEL_CTRL: begin
        bus_rdata[PTR_LSB +: PTR_W] = tm_ptr;
        bus_rdata[WREN_BIT]         = wren;
      end
      SEL_TVAL: bus_rdata = tm_pair;
      SEL_ACFG: bus_rdata[PTR_LSB +: PTR_W] = al_ptr;
      SEL_AVAL: bus_rdata = al_pair;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tkw_window_chk.sv
module tkw_window_chk
  import tkw_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STORE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_be,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wr_unlock,
  input logic              wren,
  input logic              tm_step,
  input logic              al_step,
  input ptr_t              tm_ptr,
  input ptr_t              al_ptr,
  input logic [STORE_W-1:0] tm_store,
  input logic [STORE_W-1:0] al_store
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  a_r4_tm_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_step && tm_ptr != '0) |=> (tm_ptr == $past(tm_ptr) - ptr_t'(1)));

  a_r4_al_step: assert property (@(posedge clk) disable iff (!rst_n)
    (al_step && al_ptr != '0) |=> (al_ptr == $past(al_ptr) - ptr_t'(1)));

  a_r4_lo_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == 2'd1 && bus_be == 2'b01) |=> $stable(tm_ptr));

  a_r5_tm_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_step && tm_ptr == '0) |=> (tm_ptr == '0));

  a_r5_al_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (al_step && al_ptr == '0) |=> (al_ptr == '0));

  a_r6_rd_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |-> tm_step);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !wren) |=> $stable(tm_store));

  a_r8_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_be[1] && !wr_unlock && !wren) |=> !wren);

  a_r9_alarm_free: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> $stable(tm_store));

  a_r2_unused_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1 && tm_ptr == 2'd3) |-> (bus_rdata[DATA_W-1 -: BYTE_W] == '0));

  a_r3_unused_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3 && al_ptr == 2'd3) |-> (bus_rdata == '0));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r11_reset: assert (tm_ptr == '0 && al_ptr == '0 && !wren &&
                           tm_store == '0 && al_store == '0);
    end
  end

endmodule

bind tkw_window tkw_window_chk #(
  .DATA_W  (DATA_W),
  .STORE_W (2*N_PAIRS*(DATA_W/2))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_be    (bus_be),
  .bus_rdata (bus_rdata),
  .wr_unlock (wr_unlock),
  .wren      (wren),
  .tm_step   (tm_step),
  .al_step   (al_step),
  .tm_ptr    (tm_ptr),
  .al_ptr    (al_ptr),
  .tm_store  ({tm_hi_q, tm_lo_q}),
  .al_store  ({al_hi_q, al_lo_q})
);

// File: tb/test_tkw_window.sv
module test_tkw_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wr_unlock = 1'b0;
  logic [31:0] tm_lo_q, tm_hi_q, al_lo_q, al_hi_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  tkw_window i_tkw_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wr_unlock (wr_unlock),
    .tm_lo_q   (tm_lo_q),
    .tm_hi_q   (tm_hi_q),
    .al_lo_q   (al_lo_q),
    .al_hi_q   (al_hi_q)
  );

  // Vector: req[42:39] op[38:37] (0 write, 1 read) addr[36:35] be[34:33]
  //         unlock[32] wdata[31:16] expected rdata[15:0]
  localparam int NV = 37;
  localparam logic [42:0] VECS [NV] = '{
    {4'd11, 2'd1, 2'd0, 2'b11, 1'b0, 16'h0000, 16'h0000}, // R11 control after reset
    {4'd11, 2'd1, 2'd1, 2'b11, 1'b0, 16'h0000, 16'h0000}, // R11 bytes zero
    {4'd8,  2'd0, 2'd0, 2'b11, 1'b1, 16'h2300, 16'h0000}, // R8 raise flag with unlock
    {4'd1,  2'd1, 2'd0, 2'b11, 1'b0, 16'h0000, 16'h2300}, // R1 pointer 3, flag 1
    {4'd2,  2'd0, 2'd1, 2'b11, 1'b0, 16'h5524, 16'h0000}, // R2 year, high dropped
    {4'd10, 2'd0, 2'd1, 2'b11, 1'b0, 16'h0C1F, 16'h0000}, // R10 day/month
    {4'd4,  2'd0, 2'd1, 2'b01, 1'b0, 16'h0017, 16'h0000}, // R4 low only, no step
    {4'd12, 2'd0, 2'd1, 2'b10, 1'b0, 16'h0300, 16'h0000}, // R12 weekday only
    {4'd5,  2'd0, 2'd1, 2'b11, 1'b0, 16'h3B2A, 16'h0000}, // R5 at zero
    {4'd5,  2'd1, 2'd0, 2'b11, 1'b0, 16'h0000, 16'h2000}, // R5 pointer held 0
    {4'd8,  2'd0, 2'd0, 2'b11, 1'b0, 16'h0300, 16'h0000}, // R8 clear without unlock
    {4'd2,  2'd1, 2'd1, 2'b11, 1'b0, 16'h0000, 16'h0024}, // R2 year, unused high 0
    {4'd6,  2'd1, 2'd1, 2'b11, 1'b0, 16'h0000, 16'h0C1F}, // R6 read stepped
    {4'd6,  2'd1, 2'd1, 2'b01, 1'b0, 16'h0000, 16'h0317}, // R6 low-lane read steps too
    {4'd6,  2'd1, 2'd1, 2'b11, 1'b0, 16'h0000, 16'h3B2A}, // R6 min/sec
    {4'd5,  2'd1, 2'd1, 2'b11, 1'b0, 16'h0000, 16'h3B2A}, // R5 stays at pair 0
    {4'd8,  2'd0, 2'd0, 2'b11, 1'b0, 16'h2100, 16'h0000}, // R8 raise blocked
    {4'd8,  2'd1, 2'd0, 2'b11, 1'b0, 16'h0000, 16'h0100}, // R8 flag still 0
    {4'd7,  2'd0, 2'd1, 2'b11, 1'b0, 16'hFFFF, 16'h0000}, // R7 gated write
    {4'd7,  2'd1, 2'd0, 2'b11, 1'b0, 16'h0000, 16'h0000}, // R7 pointer still stepped
    {4'd1,  2'd0, 2'd0, 2'b11, 1'b0, 16'h0100, 16'h0000}, // R1 load pointer 1
    {4'd7,  2'd1, 2'd1, 2'b11, 1'b0, 16'h0000, 16'h0317}, // R7 data unchanged
    {4'd1,  2'd0, 2'd2, 2'b11, 1'b0, 16'h0300, 16'h0000}, // R1 alarm pointer 3
    {4'd3,  2'd0, 2'd3, 2'b11, 1'b0, 16'hABCD, 16'h0000}, // R3 pair 3 ignores write
    {4'd9,  2'd0, 2'd3, 2'b11, 1'b0, 16'h0615, 16'h0000}, // R9 alarm day/month
    {4'd9,  2'd0, 2'd3, 2'b11, 1'b0, 16'h0408, 16'h0000}, // R9 alarm hour/weekday
    {4'd9,  2'd0, 2'd3, 2'b11, 1'b0, 16'h1E2D, 16'h0000}, // R9 alarm min/sec
    {4'd4,  2'd1, 2'd2, 2'b11, 1'b0, 16'h0000, 16'h0000}, // R4 alarm pointer at 0
    {4'd1,  2'd0, 2'd2, 2'b11, 1'b0, 16'h0300, 16'h0000}, // R1 alarm pointer 3
    {4'd3,  2'd1, 2'd3, 2'b11, 1'b0, 16'h0000, 16'h0000}, // R3 pair 3 reads 0
    {4'd6,  2'd1, 2'd3, 2'b11, 1'b0, 16'h0000, 16'h0615}, // R6 alarm read
    {4'd6,  2'd1, 2'd3, 2'b11, 1'b0, 16'h0000, 16'h0408}, // R6 alarm read
    {4'd5,  2'd1, 2'd3, 2'b11, 1'b0, 16'h0000, 16'h1E2D}, // R5 alarm pair 0
    {4'd6,  2'd1, 2'd0, 2'b11, 1'b0, 16'h0000, 16'h0000}, // R6 time pointer untouched
    {4'd12, 2'd0, 2'd2, 2'b01, 1'b0, 16'h0200, 16'h0000}, // R12 low lane, no load
    {4'd12, 2'd1, 2'd2, 2'b11, 1'b0, 16'h0000, 16'h0000}, // R12 pointer kept 0
    {4'd5,  2'd1, 2'd3, 2'b11, 1'b0, 16'h0000, 16'h1E2D}  // R5 alarm still pair 0
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_op(input logic rd, input logic [1:0] a, input logic [1:0] be,
                        input logic unl, input logic [15:0] wd);
    @(negedge clk);
    bus_addr  = a;
    bus_be    = be;
    bus_wdata = wd;
    wr_unlock = unl;
    bus_rd    = rd;
    bus_wr    = ~rd;
    #1ns;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    wr_unlock = 1'b0;
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1ns;
    // R11: outputs while reset is held
    chk("R11 time lo", tm_lo_q, 32'h0);
    chk("R11 alarm hi", al_hi_q, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VECS[i];
      bus_op(v[37], v[36:35], v[34:33], v[32], v[31:16]);
      if (v[37]) chk($sformatf("R%0d vector %0d", v[42:39], i), {16'h0, bus_rdata}, {16'h0, v[15:0]});
    end
    idle();

    // R2 R10 R12: stored time fields as seen by the counting engine
    chk("R2 time low bytes", tm_lo_q, 32'h241F172A);
    chk("R2 time high bytes", tm_hi_q, 32'h000C033B);
    // R3 R9: stored alarm fields
    chk("R3 alarm low bytes", al_lo_q, 32'h0015082D);
    chk("R9 alarm high bytes", al_hi_q, 32'h0006041E);

    // R6: read data comes from the current pointer, the step follows the edge
    bus_op(1'b0, 2'd0, 2'b11, 1'b0, 16'h0200);
    bus_op(1'b1, 2'd1, 2'b11, 1'b0, 16'h0000);
    chk("R6 same-cycle data", {16'h0, bus_rdata}, 32'h0C1F);
    idle();
    #1ns;
    chk("R6 after step", {16'h0, bus_rdata}, 32'h0317);

    // R1: reading the control word twice has no side effect
    bus_op(1'b1, 2'd0, 2'b11, 1'b0, 16'h0000);
    bus_op(1'b1, 2'd0, 2'b11, 1'b0, 16'h0000);
    chk("R1 control read stable", {16'h0, bus_rdata}, 32'h0100);

    // R7 R10: with unlock, a 16-bit write lands at the old pointer
    bus_op(1'b0, 2'd0, 2'b11, 1'b1, 16'h2100);
    bus_op(1'b0, 2'd1, 2'b11, 1'b0, 16'h0512);
    idle();
    chk("R10 hour/weekday write", {tm_hi_q[15:8], tm_lo_q[15:8]}, {16'h0, 8'h05, 8'h12});
    bus_addr = 2'd0;
    #1ns;
    chk("R10 pointer after", {16'h0, bus_rdata}, 32'h2000);

    // R11: reset in mid run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1ns;
    chk("R11 time cleared", tm_lo_q | tm_hi_q, 32'h0);
    chk("R11 alarm cleared", al_lo_q | al_hi_q, 32'h0);
    chk("R11 control cleared", {16'h0, bus_rdata}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule